// File: doc/BRIEF.md
# Gating Variable Euler Update Unit

This block advances one ion-channel gate of a conductance-based neuron model by a single time step. It takes the gate's opening rate, its closing rate and the present gate value, all as signed fixed-point words with 12 integer bits and 20 fraction bits. From these it derives the time constant, the steady-state value and the slope. It then applies one forward-Euler step of 0.01 time units.

All three quotients come from one sequential shift-and-subtract divider that produces one quotient bit per clock. The divider works first on the time constant, then on the steady-state value, then on the slope. A combinational multiply-accumulate then scales the slope by the fixed step, adds it to the present value, rounds the result to the word width and saturates it. A start pulse launches an update. A one-cycle done pulse reports the results, and they are held until the next update finishes.

Top module: `gate_euler_update`

## Requirements
- R1: During and after reset, before any update, `x_new`, `x_inf` and `tau` are zero and `done` and `err` are low.
- R2: `tau` equals 2^40 / S, truncated toward zero and saturated to the signed 32-bit range. S is `alpha + beta`, saturated to the signed 32-bit range.
- R3: `x_inf` equals `alpha`·2^20 / S, truncated toward zero and saturated to the signed 32-bit range.
- R4: The slope D equals (`x_inf` − X)·2^20 / `tau`, truncated toward zero and saturated. X is the captured `x_in`. The difference in the numerator is saturated before the division.
- R5: `x_new` equals floor((X·2^20 + 10486·D + 2^19) / 2^20). This is round-half-up on the 20 discarded bits, with 10486 representing 0.01. The result saturates at 0x7FFFFFFF and 0x80000000.
- R6: When S is zero (or `tau` is zero), `err` is 1, `x_new` equals X, and `x_inf` and `tau` are zero. The next update with a nonzero divisor clears `err`.
- R7: `done` is high for exactly one cycle per update. It rises no more than 168 clock cycles after the cycle in which `start` is sampled.
- R8: `x_new`, `x_inf`, `tau` and `err` change only in a cycle where `done` is high.
- R9: A `start` pulse that arrives while an update is in progress is ignored. The running update completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one update when idle |
| alpha | input | 32 | Opening rate, signed Q12.20 |
| beta | input | 32 | Closing rate, signed Q12.20 |
| x_in | input | 32 | Present gate value, signed Q12.20 |
| x_new | output | 32 | Gate value after one step |
| x_inf | output | 32 | Steady-state gate value |
| tau | output | 32 | Time constant |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divisor was zero on the last update |

## Verification
The bench sweeps rates and gate values across positive, negative, zero and extreme words. This exercises quotient sign handling: a divider that derived the sign from magnitudes alone would return positive time constants for a negative rate sum. Rate pairs that cancel to zero check that the divide-by-zero path returns the original gate value rather than garbage. A negative time constant paired with a gate value near the top of the range drives the Euler sum past its limit, which catches a missing saturation that would wrap to a large negative value. Hold checks and a second `start` pulse fired mid-update catch outputs that move between done pulses and operands that are overwritten while busy.

// File: rtl/gate_pkg.sv
package gate_pkg;

   typedef enum logic [2:0] {
      GS_IDLE,
      GS_TAU,
      GS_INF,
      GS_DER,
      GS_MAC
   } gate_state_e;

endpackage

// File: rtl/gate_shift_divider.sv
module gate_shift_divider #(
   parameter int W    = 32,
   parameter int FRAC = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic         dz
);
   localparam int NB = W + FRAC;
   localparam int CW = $clog2(NB + 1);
   localparam logic [NB-1:0] POS_LIM = {{(FRAC + 1){1'b0}}, {(W - 1){1'b1}}};
   localparam logic [NB-1:0] NEG_LIM = POS_LIM + 1'b1;
   localparam logic [W-1:0]  WMAX    = {1'b0, {(W - 1){1'b1}}};
   localparam logic [W-1:0]  WMIN    = {1'b1, {(W - 1){1'b0}}};

   logic [NB-1:0] dvd_q;
   logic [W-1:0]  rem_q;
   logic [W-1:0]  dmag_q;
   logic          neg_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;

   logic [W-1:0]  nmag;
   logic [W-1:0]  dmag;
   logic [W:0]    rem_sh;
   logic          fits;
   logic [W:0]    rem_nx;
   logic [NB-1:0] q_nx;

   assign nmag   = num[W-1] ? (~num + 1'b1) : num;
   assign dmag   = den[W-1] ? (~den + 1'b1) : den;
   assign rem_sh = {rem_q, dvd_q[NB-1]};
   assign fits   = rem_sh >= {1'b0, dmag_q};
   assign rem_nx = fits ? (rem_sh - {1'b0, dmag_q}) : rem_sh;
   assign q_nx   = {dvd_q[NB-2:0], fits};
   assign busy   = run_q;

   function automatic logic [W-1:0] pack_quo(input logic n, input logic [NB-1:0] m);
      logic [W-1:0] r;
      if (!n) begin
         r = (m > POS_LIM) ? WMAX : m[W-1:0];
      end else begin
         r = (m > NEG_LIM) ? WMIN : (~m[W-1:0] + 1'b1);
      end
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd_q  <= '0;
         rem_q  <= '0;
         dmag_q <= '0;
         neg_q  <= 1'b0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         fin    <= 1'b0;
         quo    <= '0;
         dz     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !run_q) begin
            if (den == '0) begin
               fin <= 1'b1;
               dz  <= 1'b1;
               quo <= '0;
            end else begin
               dvd_q  <= NB'(nmag) << FRAC;
               rem_q  <= '0;
               dmag_q <= dmag;
               neg_q  <= num[W-1] ^ den[W-1];
               cnt_q  <= CW'(NB);
               run_q  <= 1'b1;
               dz     <= 1'b0;
            end
         end else if (run_q) begin
            rem_q <= rem_nx[W-1:0];
            dvd_q <= q_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
               quo   <= pack_quo(neg_q, q_nx);
            end
         end
      end
   end

endmodule

// File: rtl/gate_euler_mac.sv
module gate_euler_mac #(
   parameter int W           = 32,
   parameter int FRAC        = 20,
   parameter int DT_Q        = 10486,
   parameter bit RND_HALF_UP = 1'b1
) (
   input  logic [W-1:0] x_cur,
   input  logic [W-1:0] slope,
   output logic [W-1:0] x_next
);
   localparam int AW = 2 * W + 2;
   localparam logic signed [AW-1:0] STEP = AW'(DT_Q);
   localparam logic signed [AW-1:0] MAXE = {{(AW - W + 1){1'b0}}, {(W - 1){1'b1}}};
   localparam logic signed [AW-1:0] MINE = ~MAXE;

   logic signed [AW-1:0] x_ext;
   logic signed [AW-1:0] s_ext;
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] bias;
   logic signed [AW-1:0] shifted;

   assign x_ext = AW'($signed(x_cur));
   assign s_ext = AW'($signed(slope));

   generate
      if (RND_HALF_UP) begin : g_round
         assign bias = AW'(1) <<< (FRAC - 1);
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   assign acc     = (x_ext <<< FRAC) + (s_ext * STEP) + bias;
   assign shifted = acc >>> FRAC;

   always_comb begin
      if (shifted > MAXE) begin
         x_next = MAXE[W-1:0];
      end else if (shifted < MINE) begin
         x_next = MINE[W-1:0];
      end else begin
         x_next = shifted[W-1:0];
      end
   end

endmodule

// File: rtl/gate_euler_update.sv
module gate_euler_update
   import gate_pkg::*;
#(
   parameter int W           = 32,
   parameter int FRAC        = 20,
   parameter int DT_Q        = 10486,
   parameter bit RND_HALF_UP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] alpha,
   input  logic [W-1:0] beta,
   input  logic [W-1:0] x_in,
   output logic [W-1:0] x_new,
   output logic [W-1:0] x_inf,
   output logic [W-1:0] tau,
   output logic         done,
   output logic         err
);
   localparam logic [W-1:0] ONE  = W'(1) << FRAC;
   localparam logic [W-1:0] WMAX = {1'b0, {(W - 1){1'b1}}};
   localparam logic [W-1:0] WMIN = {1'b1, {(W - 1){1'b0}}};

   generate
      if (FRAC < 1 || FRAC > W - 2) begin : g_bad_frac
         $error("gate_euler_update: FRAC must lie in 1..W-2");
      end
      if (DT_Q <= 0) begin : g_bad_step
         $error("gate_euler_update: DT_Q must be positive");
      end
      if (W < 8) begin : g_bad_width
         $error("gate_euler_update: W must be at least 8");
      end
   endgenerate

   gate_state_e  st_q;
   logic [W-1:0] a_q;
   logic [W-1:0] x_q;
   logic [W-1:0] s_q;
   logic [W-1:0] tau_q;
   logic [W-1:0] xinf_q;
   logic [W-1:0] der_q;
   logic         div_go;
   logic [W-1:0] div_num;
   logic [W-1:0] div_den;
   logic         div_busy;
   logic         div_fin;
   logic [W-1:0] div_quo;
   logic         div_dz;
   logic [W-1:0] mac_out;
   logic         busy_w;

   assign busy_w = (st_q != GS_IDLE);

   function automatic logic [W-1:0] sat_arith(input logic [W-1:0] p, input logic [W-1:0] q,
                                              input logic sub);
      logic signed [W:0] r;
      if (sub) r = $signed({p[W-1], p}) - $signed({q[W-1], q});
      else     r = $signed({p[W-1], p}) + $signed({q[W-1], q});
      if (r[W] != r[W-1]) return r[W] ? WMIN : WMAX;
      return r[W-1:0];
   endfunction

   gate_shift_divider #(
      .W   (W),
      .FRAC(FRAC)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (div_num),
      .den  (div_den),
      .busy (div_busy),
      .fin  (div_fin),
      .quo  (div_quo),
      .dz   (div_dz)
   );

   gate_euler_mac #(
      .W          (W),
      .FRAC       (FRAC),
      .DT_Q       (DT_Q),
      .RND_HALF_UP(RND_HALF_UP)
   ) u_mac (
      .x_cur (x_q),
      .slope (der_q),
      .x_next(mac_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= GS_IDLE;
         a_q     <= '0;
         x_q     <= '0;
         s_q     <= '0;
         tau_q   <= '0;
         xinf_q  <= '0;
         der_q   <= '0;
         div_go  <= 1'b0;
         div_num <= '0;
         div_den <= '0;
         x_new   <= '0;
         x_inf   <= '0;
         tau     <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         div_go <= 1'b0;
         done   <= 1'b0;
         unique case (st_q)
            GS_IDLE: begin
               if (start) begin
                  a_q     <= alpha;
                  x_q     <= x_in;
                  s_q     <= sat_arith(alpha, beta, 1'b0);
                  div_num <= ONE;
                  div_den <= sat_arith(alpha, beta, 1'b0);
                  div_go  <= 1'b1;
                  st_q    <= GS_TAU;
               end
            end
            GS_TAU: begin
               if (div_fin && div_dz) begin
                  x_new <= x_q;
                  x_inf <= '0;
                  tau   <= '0;
                  err   <= 1'b1;
                  done  <= 1'b1;
                  st_q  <= GS_IDLE;
               end else if (div_fin) begin
                  tau_q   <= div_quo;
                  div_num <= a_q;
                  div_den <= s_q;
                  div_go  <= 1'b1;
                  st_q    <= GS_INF;
               end
            end
            GS_INF: begin
               if (div_fin) begin
                  xinf_q  <= div_quo;
                  div_num <= sat_arith(div_quo, x_q, 1'b1);
                  div_den <= tau_q;
                  div_go  <= 1'b1;
                  st_q    <= GS_DER;
               end
            end
            GS_DER: begin
               if (div_fin && div_dz) begin
                  x_new <= x_q;
                  x_inf <= '0;
                  tau   <= '0;
                  err   <= 1'b1;
                  done  <= 1'b1;
                  st_q  <= GS_IDLE;
               end else if (div_fin) begin
                  der_q <= div_quo;
                  st_q  <= GS_MAC;
               end
            end
            GS_MAC: begin
               x_new <= mac_out;
               x_inf <= xinf_q;
               tau   <= tau_q;
               err   <= 1'b0;
               done  <= 1'b1;
               st_q  <= GS_IDLE;
            end
            default: st_q <= GS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/gate_euler_checker.sv
module gate_euler_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         done,
   input logic         err,
   input logic [W-1:0] x_new,
   input logic [W-1:0] x_inf,
   input logic [W-1:0] tau,
   input logic [W-1:0] x_hold,
   input logic         busy
);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R7

   AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(x_new) && $stable(x_inf) && $stable(tau) && $stable(err))); // R8

   AST_ZERO_DIV_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (x_new == x_hold)); // R6

   AST_ZERO_DIV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (tau == '0 && x_inf == '0)); // R6

   AST_OPERANDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(x_hold)); // R9

endmodule

bind gate_euler_update gate_euler_checker #(
   .W(W)
) i_gate_euler_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .done  (done),
   .err   (err),
   .x_new (x_new),
   .x_inf (x_inf),
   .tau   (tau),
   .x_hold(x_q),
   .busy  (busy_w)
);

// File: tb/test_gate_euler_update.sv
module test_gate_euler_update;

   localparam int  LAT_MAX = 168;
   localparam longint QMAX = 64'sd2147483647;
   localparam longint QMIN = -64'sd2147483648;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] alpha = '0;
   logic [31:0] beta = '0;
   logic [31:0] x_in = '0;
   logic [31:0] x_new;
   logic [31:0] x_inf;
   logic [31:0] tau;
   logic        done;
   logic        err;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   gate_euler_update i_gate_euler_update (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .alpha(alpha),
      .beta (beta),
      .x_in (x_in),
      .x_new(x_new),
      .x_inf(x_inf),
      .tau  (tau),
      .done (done),
      .err  (err)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer than 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic longint sat(input longint v);
      if (v > QMAX) return QMAX;
      if (v < QMIN) return QMIN;
      return v;
   endfunction

   function automatic longint qdiv(input longint n, input longint d);
      longint mag;
      bit     neg;
      if (d == 0) return 0;
      mag = ((n < 0 ? -n : n) <<< 20) / (d < 0 ? -d : d);
      neg = (n < 0) ^ (d < 0);
      if (!neg) return (mag > QMAX) ? QMAX : mag;
      return (mag > -QMIN) ? QMIN : -mag;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks = checks + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_case(input longint a, input longint b, input longint x, input bit poke);
      longint s, e_tau, e_inf, diff, d, acc, e_new;
      bit     e_err;
      int     n;
      longint h_new, h_inf, h_tau;
      s     = sat(a + b);
      e_err = (s == 0);
      e_tau = qdiv(64'sd1 <<< 20, s);
      e_inf = qdiv(a, s);
      diff  = sat(e_inf - x);
      if (!e_err && e_tau == 0) e_err = 1'b1;
      d     = qdiv(diff, e_tau);
      acc   = (x <<< 20) + 64'sd10486 * d + (64'sd1 <<< 19);
      e_new = sat(acc >>> 20);
      if (e_err) begin
         e_new = x;
         e_tau = 0;
         e_inf = 0;
      end
      @(negedge clk);
      alpha = a[31:0];
      beta  = b[31:0];
      x_in  = x[31:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < LAT_MAX + 4) begin
         if (poke && n == 10) begin
            // R9: a second start with other operands must be ignored
            alpha = 32'h0030_0000;
            beta  = 32'h0001_0000;
            x_in  = 32'h0002_0000;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n = n + 1;
      end
      start = 1'b0;
      check("R7 done within latency bound", (done && n <= LAT_MAX) ? 1 : 0, 1);
      check("R6 err flag", longint'(err), longint'(e_err));
      check("R2 tau", longint'($signed(tau)), e_tau);
      check("R3 x_inf", longint'($signed(x_inf)), e_inf);
      check(poke ? "R9 x_new after ignored start" : "R4 R5 x_new",
            longint'($signed(x_new)), e_new);
      h_new = longint'($signed(x_new));
      h_inf = longint'($signed(x_inf));
      h_tau = longint'($signed(tau));
      @(negedge clk);
      check("R7 done single cycle", longint'(done), 0);
      @(negedge clk);
      @(negedge clk);
      check("R8 x_new held", longint'($signed(x_new)), h_new);
      check("R8 x_inf and tau held",
            (longint'($signed(x_inf)) == h_inf && longint'($signed(tau)) == h_tau) ? 1 : 0, 1);
   endtask

   initial begin
      longint al[7];
      longint bl[5];
      longint xl[5];
      al = '{0, 1, 64'sh0010_0000, 64'sh0000_A3D7, 64'sh7FFF_FFFF, -64'sh0008_0000, 64'sh0050_0000};
      bl = '{0, 64'sh0002_0000, 64'sh0010_0000, 64'sh7FFF_FFFF, -64'sh0010_0000};
      xl = '{0, 64'sh0008_0000, -64'sh0010_0000, 64'sh7FFF_F000, -64'sh8000_0000};
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 reset x_new", longint'(x_new), 0);
      check("R1 reset x_inf/tau", longint'(x_inf | tau), 0);
      check("R1 reset done/err", longint'({done, err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", longint'({done, err}), 0);
      // R2 R3 R4 R5 R6: sweep across rate and gate corners
      foreach (al[i]) begin
         foreach (bl[j]) begin
            foreach (xl[k]) begin
               run_case(al[i], bl[j], xl[k], 1'b0);
            end
         end
      end
      // R6: cancelling rates give a zero divisor, then a good update clears err
      run_case(64'sh0010_0000, -64'sh0010_0000, 64'sh0004_0000, 1'b0);
      run_case(64'sh0001_0000, 64'sh0003_0000, 64'sh0004_0000, 1'b0);
      // R5: negative time constant pushes a high gate value past the limit
      run_case(0, -64'sh0010_0000, 64'sh7FFF_F000, 1'b0);
      // R9: start pulse in the middle of an update
      run_case(64'sh0000_A3D7, 64'sh0002_0000, 64'sh0001_8000, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule